// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the next level of memory and holds stores that have left the processor but have not yet been written below. Each slot holds one aligned multiword block with a valid bit per word. A store whose block is already held in a live slot is folded into that slot. A store to a new block takes the next free slot. The processor is stalled only when no slot matches and none is free. Slots are written to memory whole, oldest first, as one masked wide transfer over a request/acknowledge port.

Loads from the processor are checked against the buffer before they reach memory. If a buffered slot covers the requested word, the word is returned from the buffer in the same cycle. If the block is buffered but that word is not, the load waits until the buffered copies of the block have drained. A load with no conflict takes the memory port ahead of any queued write. The drain sequencer gives up the port only between transfers, never in the middle of one. The slot being drained is frozen, so a store to its block opens a new slot instead of changing data that is already on the port.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset the buffer is empty (`buf_empty`=1, `buf_full`=0), `st_ready` is 1 and `mem_req` is 0.
- R2: A store whose block address (the word address without its low log2(WORDS) bits) matches a live, non-draining slot is accepted even when the buffer is full. It sets that word's valid bit and data in the slot and allocates no slot.
- R3: A store with no live match takes a free slot. When every slot is occupied, `st_ready` stays 0 until a slot is freed.
- R4: While a slot is being drained, its data and mask do not change. A store to that block allocates a separate slot, which drains later as its own transfer.
- R5: Slots drain in allocation order. A drain holds `mem_req`=1 and `mem_we`=1 with stable fields until `mem_ack`. `mem_addr` is the block base (low bits zero), word w sits at `mem_wdata[w*DW +: DW]`, and `mem_wmask[w]` is that word's valid bit. The slot is freed on the acknowledge cycle.
- R6: A load whose word is valid in a buffered slot of the same block completes in the same cycle (`rd_done`=1, `rd_forwarded`=1), with no memory read. The data comes from the youngest slot holding that word.
- R7: A load whose block is buffered but whose word is valid in no slot of that block is held (`rd_done`=0, no read request) until those slots drain. It then reads memory.
- R8: A load with no conflict issues `mem_req`=1 with `mem_we`=0 and `mem_addr` equal to the word address whenever no write transfer is in progress. No drain starts while such a load waits. The load completes on `mem_ack`, with `rd_data`=`mem_rdata`.
- R9: `buf_full` is 1 exactly when all ENTRIES slots are occupied. `buf_empty` is 1 exactly when none is occupied. No write transfer is requested while the buffer is empty.
- R10: Every load returns the value of the latest store to that word accepted before it, or the memory contents if there is none. Once the buffer is empty, memory holds every accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| rd_valid | input | 1 | Load request, held until `rd_done` |
| rd_addr | input | AW | Load word address |
| rd_done | output | 1 | Load completes this cycle |
| rd_data | output | DW | Load result, valid with `rd_done` |
| rd_forwarded | output | 1 | Load result came from the buffer |
| mem_req | output | 1 | Memory transfer request, held until `mem_ack` |
| mem_we | output | 1 | 1 = block write from buffer, 0 = word read |
| mem_addr | output | AW | Word address of the transfer (block base for writes) |
| mem_wdata | output | WORDS*DW | Block write data, word w at bits w*DW |
| mem_wmask | output | WORDS | Per-word write enables |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |

## Verification
The bench uses four slots of four 32-bit words and a 6-bit word address. That gives only sixteen blocks, so a long pseudo-random mix of loads and stores keeps hitting the same blocks. It merges into live slots, duplicates frozen ones, fills the buffer and forces forwarding from both a draining slot and its younger twin. A memory model with an acknowledge that can be held and a variable latency keeps a drain or a bypassing read outstanding for as long as a directed case needs. This makes the full-buffer stall, merging into a full buffer and a load stalled behind a partial slot observable at the ports.

// File: rtl/scb_pkg.sv
package scb_pkg;

  // owner of the shared memory port between transfers
  typedef enum logic {
    PS_IDLE  = 1'b0,
    PS_DRAIN = 1'b1
  } port_state_e;

endpackage

// File: rtl/scb_tag_match.sv
module scb_tag_match #(
  parameter int ENTRIES = 4,
  parameter int BW      = 14
) (
  input  logic [ENTRIES-1:0]         ent_vld,
  input  logic [ENTRIES-1:0][BW-1:0] ent_blk,
  input  logic [BW-1:0]              key,
  output logic [ENTRIES-1:0]         hit
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit[e] = ent_vld[e] && (ent_blk[e] == key);
  end

endmodule

// File: rtl/scb_read_resolve.sv
module scb_read_resolve #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int DW      = 32,
  parameter int OW      = 2
) (
  input  logic [ENTRIES-1:0]                   hit,
  input  logic [ENTRIES-1:0]                   frozen,
  input  logic [ENTRIES-1:0][WORDS-1:0]        ent_wvld,
  input  logic [ENTRIES-1:0][WORDS-1:0][DW-1:0] ent_data,
  input  logic [OW-1:0]                        word,
  output logic                                 conflict,
  output logic                                 word_hit,
  output logic [DW-1:0]                        fwd_data
);

  logic          live_ok, frz_ok;
  logic [DW-1:0] live_d, frz_d;

  // a live slot is always younger than the frozen head of the same block
  always_comb begin
    live_ok = 1'b0;
    frz_ok  = 1'b0;
    live_d  = '0;
    frz_d   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (hit[e] && ent_wvld[e][word]) begin
        if (frozen[e]) begin
          frz_ok = 1'b1;
          frz_d  = ent_data[e][word];
        end else begin
          live_ok = 1'b1;
          live_d  = ent_data[e][word];
        end
      end
    end
  end

  assign conflict = |hit;
  assign word_hit = live_ok || frz_ok;
  assign fwd_data = live_ok ? live_d : frz_d;

endmodule

// File: rtl/scb_port_ctrl.sv
module scb_port_ctrl
  import scb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int OW    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_empty,
  input  logic                       rd_valid,
  input  logic                       rd_conflict,
  input  logic [AW-1:0]              rd_addr,
  input  logic [AW-OW-1:0]           head_blk,
  input  logic [WORDS-1:0]           head_wvld,
  input  logic [WORDS-1:0][DW-1:0]   head_data,
  input  logic                       mem_ack,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [AW-1:0]              mem_addr,
  output logic [WORDS*DW-1:0]        mem_wdata,
  output logic [WORDS-1:0]           mem_wmask,
  output logic                       drain_active,
  output logic                       drain_done,
  output logic                       rd_mem_done
);

  port_state_e state;
  logic        read_wants, read_go;

  assign read_wants   = rd_valid && !rd_conflict;
  assign drain_active = (state == PS_DRAIN);
  assign read_go      = read_wants && !drain_active;

  // a drain begins only when no clean load is waiting for the port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_IDLE;
    end else if (state == PS_IDLE) begin
      if (!buf_empty && !read_wants) state <= PS_DRAIN;
    end else begin
      if (mem_ack) state <= PS_IDLE;
    end
  end

  assign mem_req     = drain_active || read_go;
  assign mem_we      = drain_active;
  assign mem_addr    = drain_active ? {head_blk, {OW{1'b0}}} : rd_addr;
  assign mem_wdata   = head_data;
  assign mem_wmask   = drain_active ? head_wvld : '0;
  assign drain_done  = drain_active && mem_ack;
  assign rd_mem_done = read_go && mem_ack;

endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf
  import scb_pkg::*;
#(
  parameter int ENTRIES = 4,   // power of two, at least 2
  parameter int WORDS   = 4,   // power of two, at least 2
  parameter int DW      = 32,
  parameter int AW      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_ready,
  input  logic                rd_valid,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_done,
  output logic [DW-1:0]       rd_data,
  output logic                rd_forwarded,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [WORDS*DW-1:0] mem_wdata,
  output logic [WORDS-1:0]    mem_wmask,
  input  logic                mem_ack,
  input  logic [DW-1:0]       mem_rdata,
  output logic                buf_full,
  output logic                buf_empty
);

  localparam int EW    = $clog2(ENTRIES);
  localparam int OW    = $clog2(WORDS);
  localparam int BW    = AW - OW;
  localparam int CNT_W = EW + 1;

  function automatic logic [BW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:OW];
  endfunction

  function automatic logic [OW-1:0] word_of(input logic [AW-1:0] a);
    return a[OW-1:0];
  endfunction

  function automatic logic [WORDS-1:0] word_bit(input logic [OW-1:0] w);
    return WORDS'(1) << w;
  endfunction

  // slot storage: a circular queue whose slots may be merged in place
  logic [ENTRIES-1:0]                    ent_vld;
  logic [ENTRIES-1:0][BW-1:0]            ent_blk;
  logic [ENTRIES-1:0][WORDS-1:0]         ent_wvld;
  logic [ENTRIES-1:0][WORDS-1:0][DW-1:0] ent_data;
  logic [EW-1:0]                         head_ptr, tail_ptr;
  logic [CNT_W-1:0]                      count;

  // named events
  logic [BW-1:0]      st_blk, rd_blk;
  logic [OW-1:0]      st_word, rd_word;
  logic [ENTRIES-1:0] st_hit_vec, st_live_vec, rd_hit_vec, frozen_vec;
  logic               live_hit, st_fire, alloc_fire;
  logic               rd_conflict, rd_word_hit, rd_mem_done;
  logic [DW-1:0]      fwd_data;
  logic               drain_active, drain_done;

  assign st_blk  = blk_of(st_addr);
  assign st_word = word_of(st_addr);
  assign rd_blk  = blk_of(rd_addr);
  assign rd_word = word_of(rd_addr);

  assign frozen_vec = drain_active ? (ENTRIES'(1) << head_ptr) : '0;

  scb_tag_match #(.ENTRIES(ENTRIES), .BW(BW)) st_match_i (
    .ent_vld (ent_vld),
    .ent_blk (ent_blk),
    .key     (st_blk),
    .hit     (st_hit_vec)
  );

  scb_tag_match #(.ENTRIES(ENTRIES), .BW(BW)) rd_match_i (
    .ent_vld (ent_vld),
    .ent_blk (ent_blk),
    .key     (rd_blk),
    .hit     (rd_hit_vec)
  );

  assign st_live_vec = st_hit_vec & ~frozen_vec;
  assign live_hit    = |st_live_vec;
  assign buf_full    = (count == CNT_W'(ENTRIES));
  assign buf_empty   = (count == '0);
  assign st_ready    = live_hit || !buf_full;
  assign st_fire     = st_valid && st_ready;
  assign alloc_fire  = st_fire && !live_hit;

  // occupancy and per-word valid bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_wvld <= '0;
      head_ptr <= '0;
      tail_ptr <= '0;
      count    <= '0;
    end else begin
      if (drain_done) begin
        ent_vld[head_ptr]  <= 1'b0;
        ent_wvld[head_ptr] <= '0;
        head_ptr           <= head_ptr + EW'(1);
      end
      if (alloc_fire) begin
        ent_vld[tail_ptr]  <= 1'b1;
        ent_wvld[tail_ptr] <= word_bit(st_word);
        tail_ptr           <= tail_ptr + EW'(1);
      end else if (st_fire) begin
        for (int e = 0; e < ENTRIES; e++) begin
          if (st_live_vec[e]) ent_wvld[e][st_word] <= 1'b1;
        end
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(drain_done);
    end
  end

  // block tags and data need no reset: masked by the valid bits
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      ent_blk[tail_ptr]           <= st_blk;
      ent_data[tail_ptr][st_word] <= st_data;
    end else if (st_fire) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (st_live_vec[e]) ent_data[e][st_word] <= st_data;
      end
    end
  end

  scb_read_resolve #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DW(DW), .OW(OW)) resolve_i (
    .hit      (rd_hit_vec),
    .frozen   (frozen_vec),
    .ent_wvld (ent_wvld),
    .ent_data (ent_data),
    .word     (rd_word),
    .conflict (rd_conflict),
    .word_hit (rd_word_hit),
    .fwd_data (fwd_data)
  );

  scb_port_ctrl #(.AW(AW), .WORDS(WORDS), .DW(DW), .OW(OW)) port_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_empty    (buf_empty),
    .rd_valid     (rd_valid),
    .rd_conflict  (rd_conflict),
    .rd_addr      (rd_addr),
    .head_blk     (ent_blk[head_ptr]),
    .head_wvld    (ent_wvld[head_ptr]),
    .head_data    (ent_data[head_ptr]),
    .mem_ack      (mem_ack),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wmask    (mem_wmask),
    .drain_active (drain_active),
    .drain_done   (drain_done),
    .rd_mem_done  (rd_mem_done)
  );

  assign rd_forwarded = rd_valid && rd_conflict && rd_word_hit;
  assign rd_done      = rd_forwarded || (rd_valid && !rd_conflict && rd_mem_done);
  assign rd_data      = rd_forwarded ? fwd_data : mem_rdata;

endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int WORDS   = 4,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st_valid,
  input logic                st_ready,
  input logic                st_fire,
  input logic                live_hit,
  input logic                buf_full,
  input logic                buf_empty,
  input logic [CNT_W-1:0]    count,
  input logic                mem_req,
  input logic                mem_we,
  input logic                mem_ack,
  input logic [AW-1:0]       mem_addr,
  input logic [WORDS*DW-1:0] mem_wdata,
  input logic [WORDS-1:0]    mem_wmask,
  input logic                rd_valid,
  input logic                rd_done,
  input logic                rd_forwarded,
  input logic                rd_conflict,
  input logic                rd_word_hit
);

  AST_MERGE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire && live_hit && !(mem_req && mem_we && mem_ack) |=> count == $past(count)); // R2
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && buf_full && !live_hit |-> !st_ready); // R3
  AST_FROZEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> $stable(mem_wdata) && $stable(mem_wmask)); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && !mem_ack |=> mem_req && mem_we && $stable(mem_addr)); // R5
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wmask != '0); // R5
  AST_FWD_NO_MEMREAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_forwarded |-> rd_done && !(mem_req && !mem_we)); // R6
  AST_STALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_conflict && !rd_word_hit |-> !rd_done && !(mem_req && !mem_we)); // R7
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_conflict && !(mem_req && mem_we) |-> mem_req); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(ENTRIES)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty)); // R9
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !(mem_req && mem_we)); // R9

endmodule

bind store_coalesce_buf scb_checker #(
  .AW(AW), .DW(DW), .WORDS(WORDS), .ENTRIES(ENTRIES), .CNT_W(CNT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .st_valid     (st_valid),
  .st_ready     (st_ready),
  .st_fire      (st_fire),
  .live_hit     (live_hit),
  .buf_full     (buf_full),
  .buf_empty    (buf_empty),
  .count        (count),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_wmask    (mem_wmask),
  .rd_valid     (rd_valid),
  .rd_done      (rd_done),
  .rd_forwarded (rd_forwarded),
  .rd_conflict  (rd_conflict),
  .rd_word_hit  (rd_word_hit)
);

// File: tb/store_coalesce_buf_tb_top.sv
`timescale 1ns/1ps
module store_coalesce_buf_tb_top;
  localparam int ENTRIES = 4;
  localparam int WORDS   = 4;
  localparam int DW      = 32;
  localparam int AW      = 6;
  localparam int NW      = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                st_valid = 0, st_ready;
  logic [AW-1:0]       st_addr = '0;
  logic [DW-1:0]       st_data = '0;
  logic                rd_valid = 0, rd_done, rd_forwarded;
  logic [AW-1:0]       rd_addr = '0;
  logic [DW-1:0]       rd_data;
  logic                mem_req, mem_we;
  logic [AW-1:0]       mem_addr;
  logic [WORDS*DW-1:0] mem_wdata;
  logic [WORDS-1:0]    mem_wmask;
  logic                mem_ack = 0;
  logic [DW-1:0]       mem_rdata = '0;
  logic                buf_full, buf_empty;

  store_coalesce_buf #(.ENTRIES(ENTRIES), .WORDS(WORDS), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .rd_forwarded(rd_forwarded),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_full(buf_full), .buf_empty(buf_empty)
  );

  logic [DW-1:0]    mem_m [NW];
  logic [DW-1:0]    exp_m [NW];
  int               tests = 0;
  int               fails = 0;
  bit               hold = 0;
  int               lat = 1;
  int               cnt = 0;
  int               wr_n = 0;
  logic [AW-1:0]    wr_addr [8];
  logic [WORDS-1:0] wr_mask [8];

  // memory model: acts at falling edges, ack lasts one cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0;
      cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 0;
      cnt = 0;
    end else if (mem_req && !hold) begin
      cnt++;
      if (cnt >= lat) begin
        mem_ack = 1;
        if (mem_we) begin
          for (int w = 0; w < WORDS; w++)
            if (mem_wmask[w]) mem_m[int'(mem_addr) + w] = mem_wdata[w*DW +: DW];
          if (wr_n < 8) begin
            wr_addr[wr_n] = mem_addr;
            wr_mask[wr_n] = mem_wmask;
          end
          wr_n++;
        end else begin
          mem_rdata = mem_m[mem_addr];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit ok = 0;
    @(posedge clk); #1;
    st_valid = 1; st_addr = a; st_data = d;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk); #2;
      if (st_ready) begin ok = 1; break; end
    end
    if (!ok) begin
      st_valid = 0;
      chk(0, "R3 store never accepted", 64'(a), 64'(1));
    end else begin
      exp_m[a] = d;
      @(posedge clk); #1;
      st_valid = 0;
    end
  endtask

  logic [DW-1:0] rdv;
  bit            rdf, rdok;

  task automatic do_read(input logic [AW-1:0] a);
    rdok = 0;
    @(posedge clk); #1;
    rd_valid = 1; rd_addr = a;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk); #2;
      if (rd_done) begin rdok = 1; rdv = rd_data; rdf = rd_forwarded; break; end
    end
    if (!rdok) rd_valid = 0;
    else begin
      @(posedge clk); #1;
      rd_valid = 0;
    end
  endtask

  task automatic wait_read_done();
    rdok = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk); #2;
      if (rd_done) begin rdok = 1; rdv = rd_data; rdf = rd_forwarded; break; end
    end
    @(posedge clk); #1;
    rd_valid = 0;
  endtask

  task automatic wait_empty();
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); #2;
      if (buf_empty && !mem_req) break;
    end
  endtask

  function automatic logic [15:0] lfsr_nx(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NW; i++) begin
      mem_m[i] = 32'h5A00_0000 | i;
      exp_m[i] = 32'h5A00_0000 | i;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #2;
    // R1 reset state
    chk(buf_empty === 1'b1, "R1 empty after reset", 64'(buf_empty), 64'(1));
    chk(buf_full === 1'b0, "R1 not full after reset", 64'(buf_full), 64'(0));
    chk(st_ready === 1'b1, "R1 store ready after reset", 64'(st_ready), 64'(1));
    chk(mem_req === 1'b0, "R1 no request after reset", 64'(mem_req), 64'(0));

    // ---- frozen head, forwarding, stalled load ----
    wr_n = 0; hold = 1;
    do_store(6'h08, 32'h1111_0008);
    do_store(6'h0A, 32'h2222_000A);
    do_read(6'h0A);
    chk(rdok && rdf && rdv == 32'h2222_000A, "R6 forward from live slot", 64'(rdv), 64'h2222_000A);
    do_read(6'h08);
    chk(rdok && rdf && rdv == 32'h1111_0008, "R6 forward from draining slot", 64'(rdv), 64'h1111_0008);
    @(posedge clk); #1;
    rd_valid = 1; rd_addr = 6'h09;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(!rd_done && !(mem_req && !mem_we), "R7 partial-word load held", 64'(rd_done), 64'(0));
    end
    hold = 0;
    wait_read_done();
    chk(rdok && !rdf && rdv == exp_m[9], "R7 load reads memory after drain", 64'(rdv), 64'(exp_m[9]));
    wait_empty();
    chk(wr_n == 2, "R4 store to draining block is a separate transfer", 64'(wr_n), 64'(2));
    chk(wr_addr[0] == 6'h08 && wr_mask[0] == 4'b0001, "R5 first transfer addr/mask",
        {wr_addr[0], wr_mask[0]}, {6'h08, 4'b0001});
    chk(wr_addr[1] == 6'h08 && wr_mask[1] == 4'b0100, "R4 second transfer addr/mask",
        {wr_addr[1], wr_mask[1]}, {6'h08, 4'b0100});
    chk(mem_m[8] == 32'h1111_0008 && mem_m[10] == 32'h2222_000A, "R5 word placement",
        {mem_m[8], mem_m[10]}, {32'h1111_0008, 32'h2222_000A});

    // ---- load priority, merging, full stall ----
    wr_n = 0; hold = 1;
    @(posedge clk); #1;
    rd_valid = 1; rd_addr = 6'h30;
    @(negedge clk); #2;
    chk(mem_req && !mem_we && mem_addr == 6'h30, "R8 clean load issued", 64'(mem_addr), 64'h30);
    do_store(6'h00, 32'hA0);
    do_store(6'h01, 32'hA1);
    do_store(6'h02, 32'hA2);
    do_store(6'h03, 32'hA3);
    chk(!buf_full && !buf_empty, "R9 one slot occupied", 64'({buf_full, buf_empty}), 64'b00);
    do_store(6'h04, 32'hB4);
    do_store(6'h08, 32'hC8);
    chk(!buf_full, "R2 merged block holds one slot", 64'(buf_full), 64'(0));
    do_store(6'h0C, 32'hDC);
    chk(buf_full, "R9 full with four slots", 64'(buf_full), 64'(1));
    chk(mem_req && !mem_we, "R8 drain waits behind load", 64'(mem_we), 64'(0));
    @(posedge clk); #1;
    st_valid = 1; st_addr = 6'h10; st_data = 32'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(!st_ready, "R3 new block stalls when full", 64'(st_ready), 64'(0));
    end
    st_valid = 0;
    do_store(6'h05, 32'hB5);
    chk(buf_full, "R2 merge accepted while full", 64'(buf_full), 64'(1));
    hold = 0;
    wait_read_done();
    chk(rdok && !rdf && rdv == exp_m[6'h30], "R8 load data from memory", 64'(rdv), 64'(exp_m[6'h30]));
    wait_empty();
    chk(buf_empty && !buf_full, "R9 empty after drain", 64'({buf_full, buf_empty}), 64'b01);
    chk(wr_n == 4, "R5 four transfers", 64'(wr_n), 64'(4));
    chk(wr_addr[0] == 6'h00 && wr_mask[0] == 4'b1111, "R2 merged mask",
        {wr_addr[0], wr_mask[0]}, {6'h00, 4'b1111});
    chk(wr_addr[1] == 6'h04 && wr_mask[1] == 4'b0011, "R5 order second",
        {wr_addr[1], wr_mask[1]}, {6'h04, 4'b0011});
    chk(wr_addr[2] == 6'h08 && wr_mask[2] == 4'b0001, "R5 order third",
        {wr_addr[2], wr_mask[2]}, {6'h08, 4'b0001});
    chk(wr_addr[3] == 6'h0C && wr_mask[3] == 4'b0001, "R5 order fourth",
        {wr_addr[3], wr_mask[3]}, {6'h0C, 4'b0001});

    // ---- pseudo-random mix over sixteen blocks ----
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = lfsr_nx(lfsr_nx(lf));
      lat = 1 + (int'(lf[9:8]) % 3);
      if (lf[1:0] == 2'b00) begin
        do_read(lf[7:2]);
        chk(rdok && rdv == exp_m[lf[7:2]], "R10 load returns latest store", 64'(rdv), 64'(exp_m[lf[7:2]]));
      end else begin
        do_store(lf[7:2], {lf, ~lf} ^ DW'(i));
      end
    end
    wait_empty();
    for (int a = 0; a < NW; a++)
      chk(mem_m[a] == exp_m[a], "R10 memory after final drain", 64'(mem_m[a]), 64'(exp_m[a]));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule